// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Held P Operand

This block compares two W-bit operands, P and Q (W defaults to 8). A mode input selects the comparison type: unsigned, or two's complement. The block drives two decoded decisions, P-above-Q and P-below-Q. When the operands are equal, the two decisions are taken from a pair of cascade inputs. Wider words are compared by chaining stages. The two outputs of a lower-significance stage connect straight to the cascade inputs of the next stage up, with no glue logic. The lowest stage ties its cascade inputs low. In a signed chain, only the top stage runs in two's complement mode.

The P operand passes through a hold stage controlled by a load-enable input. While the enable is high, the live P input is compared and is also captured at each rising clock edge. While the enable is low, the last captured value is compared. A synchronous active-high reset clears the captured value to zero. Q and the mode input have no storage. The decisions and the cascade path are combinational, so a chain settles within the same cycle.

Top module: `latched_mag_cmp`

## Requirements
- R1: With `arith_mode` = 0, `above_out` is 1 exactly when the compared P is greater than Q as unsigned numbers, and `below_out` is 1 exactly when it is smaller.
- R2: With `arith_mode` = 1, both operands are read as two's complement numbers (bit W-1 is the sign) and the decisions follow that ordering.
- R3: When the compared P equals Q, `above_out` equals `above_in` and `below_out` equals `below_in`. This includes the disallowed case where both cascade inputs are 1, which gives both outputs 1.
- R4: When the compared P differs from Q, the cascade inputs have no effect on either output.
- R5: While `p_load` is 1, the compared P is the live `p_in`, visible without a clock edge. The value present at each rising edge is also captured.
- R6: While `p_load` is 0, the compared P is the value captured at the last rising edge at which `p_load` was 1, whatever `p_in` does.
- R7: A rising edge with `rst` = 1 clears the captured P to zero, taking priority over a load.
- R8: Unless both cascade inputs are 1, `above_out` and `below_out` are never 1 together.
- R9: Two stages chained (low-stage outputs into high-stage cascade inputs, low stage unsigned with cascade inputs 0, high stage in the chosen mode) compare 16-bit words correctly, unsigned or signed.
- R10: A change of `q_in` or `arith_mode` alters the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the P capture register |
| rst | input | 1 | Synchronous active-high clear of the captured P |
| p_load | input | 1 | 1: P is transparent and captured; 0: P is held |
| p_in | input | W | P operand |
| q_in | input | W | Q operand |
| arith_mode | input | 1 | 0 unsigned, 1 two's complement |
| above_in | input | 1 | Cascade: P above Q from the lower stage |
| below_in | input | 1 | Cascade: P below Q from the lower stage |
| above_out | output | 1 | P above Q (or cascade when equal) |
| below_out | output | 1 | P below Q (or cascade when equal) |

## Verification
The bench targets the operand pairs where signed and unsigned orderings disagree (0x80 against 0x7F, 0xFF against 0x01). A design with the sign handling inverted or missing reports the opposite decision there. Equal words are driven with each cascade pattern, including both inputs high, to catch a stage that drops or swaps the cascade inputs. Unequal words are driven with cascade inputs set against the result, to catch one that lets them leak through. The hold path is tested by changing `p_in` after the enable falls, by resetting with a nonzero input, and by moving Q and the mode while P is held. A two-stage chain is then run in both modes to expose a wrong cascade priority across the slice boundary.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic {
    CMP_UNSIGNED = 1'b0,
    CMP_SIGNED   = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic above;
    logic below;
  } cmp_dec_t;
endpackage

// File: rtl/lmc_p_hold.sv
module lmc_p_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] held,
  output logic [W-1:0] eff
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (load) held_q <= d;
  end

  assign held = held_q;
  assign eff  = load ? d : held_q;
endmodule

// File: rtl/lmc_slice_cmp.sv
module lmc_slice_cmp
  import lmc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cmp_mode_e    mode,
  output cmp_dec_t     dec,
  output logic         same
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_k, b_k;

  // Signed order equals unsigned order once the sign bits are inverted.
  always_comb begin
    a_k = a;
    b_k = b;
    if (mode == CMP_SIGNED) begin
      a_k[MSB] = ~a[MSB];
      b_k[MSB] = ~b[MSB];
    end
  end

  // Ripple from MSB: first differing bit decides.
  logic [W:0] gt_c, lt_c;
  assign gt_c[W] = 1'b0;
  assign lt_c[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    logic undecided;
    assign undecided = ~gt_c[i+1] & ~lt_c[i+1];
    assign gt_c[i] = gt_c[i+1] | (undecided &  a_k[i] & ~b_k[i]);
    assign lt_c[i] = lt_c[i+1] | (undecided & ~a_k[i] &  b_k[i]);
  end

  assign dec.above = gt_c[0];
  assign dec.below = lt_c[0];
  assign same      = ~gt_c[0] & ~lt_c[0];
endmodule

// File: rtl/lmc_cascade_mux.sv
module lmc_cascade_mux
  import lmc_pkg::*;
(
  input  cmp_dec_t local_dec,
  input  logic     same,
  input  cmp_dec_t chain_dec,
  output cmp_dec_t out_dec
);
  assign out_dec = same ? chain_dec : local_dec;
endmodule

// File: rtl/latched_mag_cmp.sv
module latched_mag_cmp
  import lmc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         p_load,
  input  logic [W-1:0] p_in,
  input  logic [W-1:0] q_in,
  input  logic         arith_mode,
  input  logic         above_in,
  input  logic         below_in,
  output logic         above_out,
  output logic         below_out
);
  logic [W-1:0] p_held;
  logic [W-1:0] p_eff;
  cmp_dec_t     local_dec;
  cmp_dec_t     chain_dec;
  cmp_dec_t     out_dec;
  logic         same;
  cmp_mode_e    mode;

  assign mode            = cmp_mode_e'(arith_mode);
  assign chain_dec.above = above_in;
  assign chain_dec.below = below_in;

  lmc_p_hold #(.W(W)) u_hold (
    .clk (clk),
    .rst (rst),
    .load(p_load),
    .d   (p_in),
    .held(p_held),
    .eff (p_eff)
  );

  lmc_slice_cmp #(.W(W)) u_cmp (
    .a   (p_eff),
    .b   (q_in),
    .mode(mode),
    .dec (local_dec),
    .same(same)
  );

  lmc_cascade_mux u_mux (
    .local_dec(local_dec),
    .same     (same),
    .chain_dec(chain_dec),
    .out_dec  (out_dec)
  );

  assign above_out = out_dec.above;
  assign below_out = out_dec.below;
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         p_load,
  input logic [W-1:0] p_in,
  input logic [W-1:0] q_in,
  input logic         arith_mode,
  input logic         above_in,
  input logic         below_in,
  input logic         above_out,
  input logic         below_out,
  input logic [W-1:0] p_eff,
  input logic [W-1:0] p_held
);
  p_uns_r1: assert property (@(posedge clk) disable iff (rst)
    (!arith_mode && (p_eff > q_in)) |-> (above_out && !below_out));

  p_sgn_r2: assert property (@(posedge clk) disable iff (rst)
    (arith_mode && ($signed(p_eff) < $signed(q_in))) |-> (below_out && !above_out));

  p_eq_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (p_eff == q_in) |-> ((above_out == above_in) && (below_out == below_in)));

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(p_load) && !$past(rst)) |-> (p_held == $past(p_in)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(p_load) && !$past(rst)) |-> $stable(p_held));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (p_held == '0));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(above_in && below_in) |-> !(above_out && below_out));
endmodule

bind latched_mag_cmp lmc_checker #(.W(W)) u_lmc_chk (
  .clk       (clk),
  .rst       (rst),
  .p_load    (p_load),
  .p_in      (p_in),
  .q_in      (q_in),
  .arith_mode(arith_mode),
  .above_in  (above_in),
  .below_in  (below_in),
  .above_out (above_out),
  .below_out (below_out),
  .p_eff     (p_eff),
  .p_held    (p_held)
);

// File: tb/test_latched_mag_cmp.sv
module test_latched_mag_cmp;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_load = 1'b0;
  logic [W-1:0] p_in = 8'hAA;
  logic [W-1:0] q_in = '0;
  logic arith_mode = 1'b0;
  logic above_in = 1'b0;
  logic below_in = 1'b0;
  logic above_out, below_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  latched_mag_cmp #(.W(W)) i_latched_mag_cmp (
    .clk(clk), .rst(rst), .p_load(p_load), .p_in(p_in), .q_in(q_in),
    .arith_mode(arith_mode), .above_in(above_in), .below_in(below_in),
    .above_out(above_out), .below_out(below_out)
  );

  // Two-stage 16-bit chain (R9)
  logic [15:0] cp, cq;
  logic        c_mode;
  logic        lo_gt, lo_lt, hi_gt, hi_lt;

  latched_mag_cmp #(.W(8)) i_lo (
    .clk(clk), .rst(rst), .p_load(1'b1), .p_in(cp[7:0]), .q_in(cq[7:0]),
    .arith_mode(1'b0), .above_in(1'b0), .below_in(1'b0),
    .above_out(lo_gt), .below_out(lo_lt)
  );
  latched_mag_cmp #(.W(8)) i_hi (
    .clk(clk), .rst(rst), .p_load(1'b1), .p_in(cp[15:8]), .q_in(cq[15:8]),
    .arith_mode(c_mode), .above_in(lo_gt), .below_in(lo_lt),
    .above_out(hi_gt), .below_out(hi_lt)
  );

  // {arith, p, q, above_in, below_in, exp_above, exp_below}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'h05, 8'h03, 2'b00, 2'b10},  // R1
    {1'b0, 8'h80, 8'h7F, 2'b00, 2'b10},  // R1 unsigned
    {1'b1, 8'h80, 8'h7F, 2'b00, 2'b01},  // R2 -128 < 127
    {1'b1, 8'hFF, 8'h01, 2'b00, 2'b01},  // R2 -1 < 1
    {1'b0, 8'hFF, 8'h01, 2'b00, 2'b10},  // R1
    {1'b1, 8'h7F, 8'h80, 2'b00, 2'b10},  // R2
    {1'b0, 8'h3C, 8'h3C, 2'b10, 2'b10},  // R3
    {1'b1, 8'h3C, 8'h3C, 2'b01, 2'b01},  // R3
    {1'b0, 8'h00, 8'h00, 2'b00, 2'b00},  // R3
    {1'b0, 8'h10, 8'h20, 2'b10, 2'b01},  // R4
    {1'b1, 8'hFE, 8'hFE, 2'b11, 2'b11},  // R3 both cascade high
    {1'b1, 8'h00, 8'hFF, 2'b01, 2'b10}   // R2 and R4: 0 > -1
  };

  task automatic check2(input string tag, input logic ag, input logic al,
                        input logic eg, input logic el);
    n_chk++;
    if (ag !== eg || al !== el) begin
      n_bad++;
      $display("FAIL %s: got above=%b below=%b expected above=%b below=%b",
               tag, ag, al, eg, el);
    end
  endtask

  function automatic logic [1:0] ref_cmp(input logic md, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic gi,
                                         input logic li);
    logic gt, lt;
    if (md) begin
      gt = $signed(a) > $signed(b);
      lt = $signed(a) < $signed(b);
    end else begin
      gt = a > b;
      lt = a < b;
    end
    if (!gt && !lt) return {gi, li};
    return {gt, lt};
  endfunction

  task automatic tick_off();
    @(posedge clk);
    #2;
  endtask

  initial begin
    // Reset with a nonzero P on the input and load low (R7)
    repeat (3) tick_off();
    rst = 1'b0;
    #1;
    q_in = 8'h00;
    #1 check2("R7 reset clears held P (q=0)", above_out, below_out, 1'b0, 1'b0);
    q_in = 8'h01;
    #1 check2("R7 reset clears held P (q=1)", above_out, below_out, 1'b0, 1'b1);

    // Table walk, transparent P (R1/R2/R3/R4/R5)
    p_load = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {arith_mode, p_in, q_in, above_in, below_in} = VEC[i][20:2];
      #1 check2($sformatf("R1/R2/R3/R4/R5 vector %0d", i), above_out, below_out,
                VEC[i][1], VEC[i][0]);
      #1;
    end

    // Random against reference (R1/R2/R3/R4/R8)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] e;
      arith_mode = 1'($urandom);
      p_in = 8'($urandom);
      q_in = (i % 5 == 0) ? p_in : 8'($urandom);
      above_in = 1'($urandom);
      below_in = above_in ? 1'b0 : 1'($urandom);
      e = ref_cmp(arith_mode, p_in, q_in, above_in, below_in);
      #1 check2("R1/R2/R3/R4/R8 random", above_out, below_out, e[1], e[0]);
      #1;
    end
    above_in = 1'b0;
    below_in = 1'b0;

    // Hold (R6) and combinational Q/mode path (R10)
    tick_off();
    p_in = 8'h40;
    arith_mode = 1'b0;
    tick_off();
    p_load = 1'b0;
    p_in = 8'h00;
    q_in = 8'h30;
    #1 check2("R6 held 0x40 vs 0x30", above_out, below_out, 1'b1, 1'b0);
    tick_off();
    p_in = 8'hFF;
    #1 check2("R6 p_in ignored while held", above_out, below_out, 1'b1, 1'b0);
    q_in = 8'h50;
    #1 check2("R10 q change without clock", above_out, below_out, 1'b0, 1'b1);
    q_in = 8'hC0;
    #1 check2("R10 unsigned 0x40 vs 0xC0", above_out, below_out, 1'b0, 1'b1);
    arith_mode = 1'b1;
    #1 check2("R10 signed 0x40 vs 0xC0", above_out, below_out, 1'b1, 1'b0);
    q_in = 8'h40;
    above_in = 1'b1;
    below_in = 1'b1;
    #1 check2("R3 held equal both cascade high", above_out, below_out, 1'b1, 1'b1);
    above_in = 1'b0;
    below_in = 1'b0;

    // Reset priority over load (R7)
    p_load = 1'b1;
    p_in = 8'h77;
    rst = 1'b1;
    tick_off();
    rst = 1'b0;
    p_load = 1'b0;
    arith_mode = 1'b0;
    q_in = 8'h00;
    #1 check2("R7 reset beats load", above_out, below_out, 1'b0, 1'b0);

    // 16-bit chain (R9)
    cp = 16'h0100; cq = 16'h00FF; c_mode = 1'b0;
    #1 check2("R9 chain 0x0100>0x00FF", hi_gt, hi_lt, 1'b1, 1'b0);
    cp = 16'h8000; cq = 16'h7FFF; c_mode = 1'b1;
    #1 check2("R9 chain signed 0x8000<0x7FFF", hi_gt, hi_lt, 1'b0, 1'b1);
    cp = 16'h12F0; cq = 16'h1234; c_mode = 1'b1;
    #1 check2("R9 chain low slice decides", hi_gt, hi_lt, 1'b1, 1'b0);
    cp = 16'hABCD; cq = 16'hABCD; c_mode = 1'b0;
    #1 check2("R9 chain equal", hi_gt, hi_lt, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) begin
      logic eg, el;
      c_mode = 1'($urandom);
      cp = 16'($urandom);
      cq = (i % 7 == 0) ? {cp[15:8], 8'($urandom)} : 16'($urandom);
      if (c_mode) begin
        eg = $signed(cp) > $signed(cq);
        el = $signed(cp) < $signed(cq);
      end else begin
        eg = cp > cq;
        el = cp < cq;
      end
      #1 check2("R9 chain random", hi_gt, hi_lt, eg, el);
      #1;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule